// File: doc/BRIEF.md
# SENT Receive-Clock Drift Compensator

This block generates the receive tick for one channel of a single-edge nibble transmission (SENT) receiver. A prescaler counter runs on the fast protocol clock and emits one tick each time it rolls over at the active divide value. While the channel is enabled, the same clock domain measures the time between successive falling edges of the already-filtered input line.

A pulse whose length is close to 56 ticks at the programmed rate is taken as the calibration (synchronization) pulse. A serial divider then turns its length into a corrected divide value, so that the tick period follows the sensor's real clock. The corrected value is exposed on an output and replaces the programmed value for the tick generator. It is recomputed on every calibration pulse and otherwise stays unchanged. A one-cycle strobe marks each update, so the nibble decoder downstream can switch rate at the message boundary.

If a pause pulse is mistaken for a calibration pulse, the error only lasts until the next genuine synchronization pulse, because the block recomputes on every qualifying pulse.

Top module: `sent_rx_clk_comp`

## Requirements
- R1: After reset, and on every clock edge where `en_i` is low, `tick_o`, `comp_valid_o` and `comp_presc_o` all read zero on the following cycle.
- R2: When no falling edge occurs, `tick_o` pulses high for one cycle every E clock cycles. E is `comp_presc_o` when that is nonzero, otherwise `presc_i`, and a value of 0 acts as 1.
- R3: A falling edge on `rx_i` restarts the prescaler. The edge counts when the previous cycle's sample was 1 and the present sample is 0. The first tick after it appears E+1 sampling cycles later (E edges after the edge that saw the fall), with no tick before that.
- R4: The length L of a pulse is the number of clock cycles between two successive falling edges. The pulse qualifies only if `presc_i` P is nonzero and 168·P ≤ 4·L ≤ 280·P, which is ±25 % around 56·P.
- R5: A qualifying pulse loads `comp_presc_o` with floor((L+28)/56), which is L/56 rounded half up. The load happens no later than MEAS_W+2 cycles after the closing falling edge. `comp_valid_o` is high for exactly that one cycle, and a loaded value is never zero.
- R6: A pulse that does not qualify leaves `comp_presc_o` unchanged and raises no `comp_valid_o`.
- R7: The first falling edge after reset or after enable does not close a pulse. The length measurement starts saturated, and a saturated measurement never qualifies.
- R8: Every qualifying pulse computes a fresh value that replaces the previous one. A value taken from a pause pulse is therefore corrected by the next synchronization pulse.
- R9: Once `comp_presc_o` is nonzero, `presc_i` no longer affects the tick period. It still sets the qualification window.
- R10: Lowering and then raising `en_i` clears the corrected value, so the tick period falls back to `presc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast protocol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| presc_i | input | PRESC_W | Programmed divide value |
| rx_i | input | 1 | Filtered SENT input line |
| tick_o | output | 1 | Receive tick, one cycle wide |
| comp_presc_o | output | PRESC_W+1 | Corrected divide value, zero when none |
| comp_valid_o | output | 1 | One-cycle strobe on each update |

## Verification
The properties assume that `rx_i` is already glitch-free. They also assume that two qualifying pulses are never closer together than the divider latency, so a strobe cannot follow a strobe. The stimulus holds every low phase for several cycles and spaces qualifying pulses at least 42 cycles apart. It also keeps the gaps between test cases short enough that the unmeasured pulse before each case falls below the lower window bound.

// File: rtl/sent_clk_pkg.sv
`timescale 1ns/1ps
package sent_clk_pkg;
  localparam int unsigned SYNC_TICKS = 56;
  localparam int unsigned WIN_LO_Q   = 3;  // lower window in quarters of nominal
  localparam int unsigned WIN_HI_Q   = 5;  // upper window in quarters of nominal
  localparam int unsigned WIN_SHIFT  = 2;  // quarters -> multiply length by 4
endpackage

// File: rtl/sent_pulse_meas.sv
`timescale 1ns/1ps
module sent_pulse_meas
  import sent_clk_pkg::*;
#(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned MEAS_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               rx_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               fall_o,
  output logic               qual_o,
  output logic [MEAS_W-1:0]  len_o
);
  localparam int unsigned CW = MEAS_W + PRESC_W + 4;

  logic              rx_q;
  logic [MEAS_W-1:0] cnt_q;
  logic              sat;
  logic [CW-1:0]     len4, nom, lo_lim, hi_lim;

  assign sat    = &cnt_q;
  assign fall_o = en_i & rx_q & ~rx_i;
  assign len_o  = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= 1'b0;
      cnt_q <= '1;
    end else begin
      rx_q <= rx_i;
      if (!en_i)       cnt_q <= '1;
      else if (fall_o) cnt_q <= '0;
      else if (!sat)   cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    len4   = CW'(len_o) << WIN_SHIFT;
    nom    = CW'(presc_i) * CW'(SYNC_TICKS);
    lo_lim = nom * CW'(WIN_LO_Q);
    hi_lim = nom * CW'(WIN_HI_Q);
  end

  assign qual_o = fall_o && !sat && (presc_i != '0) && (len4 >= lo_lim) && (len4 <= hi_lim);
endmodule

// File: rtl/sent_round_div.sv
`timescale 1ns/1ps
module sent_round_div #(
  parameter int unsigned DVD_W   = 17,
  parameter int unsigned DIVISOR = 56,
  parameter int unsigned QUO_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dvd_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam int unsigned REM_W = $clog2(DIVISOR);
  localparam int unsigned CNT_W = $clog2(DVD_W);

  logic [REM_W-1:0] rem_q, rem_nxt;
  logic [DVD_W-1:0] dq_q, dq_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [REM_W:0]   trial, diff;
  logic             ge;

  // restoring division, one quotient bit per cycle, MSB first
  always_comb begin
    trial   = {rem_q, dq_q[DVD_W-1]};
    ge      = trial >= (REM_W+1)'(DIVISOR);
    diff    = trial - (REM_W+1)'(DIVISOR);
    rem_nxt = ge ? diff[REM_W-1:0] : trial[REM_W-1:0];
    dq_nxt  = {dq_q[DVD_W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      rem_q  <= '0;
      dq_q   <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_o <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        rem_q  <= '0;
        dq_q   <= dvd_i;
        cnt_q  <= CNT_W'(DVD_W - 1);
      end
    end else begin
      rem_q <= rem_nxt;
      dq_q  <= dq_nxt;
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0) && !clr_i;
  assign quo_o  = dq_nxt[QUO_W-1:0];
endmodule

// File: rtl/sent_tick_gen.sv
`timescale 1ns/1ps
module sent_tick_gen #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, last;

  // divide value 0 behaves as 1
  assign last = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i || restart_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sent_rx_clk_comp.sv
`timescale 1ns/1ps
module sent_rx_clk_comp
  import sent_clk_pkg::*;
#(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned MEAS_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               rx_i,
  output logic               tick_o,
  output logic [PRESC_W:0]   comp_presc_o,
  output logic               comp_valid_o
);
  localparam int unsigned DVD_W  = MEAS_W + 1;
  localparam int unsigned COMP_W = PRESC_W + 1;

  logic              fall, qual, div_busy, div_done;
  logic [MEAS_W-1:0] len;
  logic [DVD_W-1:0]  dvd;
  logic [COMP_W-1:0] quo, comp_q, eff_div;

  sent_pulse_meas #(.PRESC_W(PRESC_W), .MEAS_W(MEAS_W)) i_meas (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .rx_i    (rx_i),
    .presc_i (presc_i),
    .fall_o  (fall),
    .qual_o  (qual),
    .len_o   (len)
  );

  // add half the divisor for round-half-up
  assign dvd = {1'b0, len} + DVD_W'(SYNC_TICKS / 2);

  sent_round_div #(.DVD_W(DVD_W), .DIVISOR(SYNC_TICKS), .QUO_W(COMP_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .start_i (qual && !div_busy),
    .dvd_i   (dvd),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q       <= '0;
      comp_valid_o <= 1'b0;
    end else if (!en_i) begin
      comp_q       <= '0;
      comp_valid_o <= 1'b0;
    end else begin
      comp_valid_o <= div_done;
      if (div_done) comp_q <= quo;
    end
  end

  assign eff_div      = (comp_q != '0) ? comp_q : {1'b0, presc_i};
  assign comp_presc_o = comp_q;

  sent_tick_gen #(.W(COMP_W)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (fall),
    .div_i     (eff_div),
    .tick_o    (tick_o)
  );
endmodule

// File: rtl/sent_rx_clk_comp_chk.sv
`timescale 1ns/1ps
module sent_rx_clk_comp_chk #(
  parameter int unsigned PRESC_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [PRESC_W-1:0] presc_i,
  input logic               rx_i,
  input logic               tick_o,
  input logic [PRESC_W:0]   comp_presc_o,
  input logic               comp_valid_o
);
  // R1
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (comp_presc_o == '0 && !tick_o && !comp_valid_o));

  // R5
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_valid_o |=> !comp_valid_o);

  // R5
  valid_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_valid_o |-> comp_presc_o != '0);

  // R6
  comp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !comp_valid_o) |-> $stable(comp_presc_o));

  // R3
  fall_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(rx_i) && !rx_i) |=> !tick_o);

  logic unused_presc;
  assign unused_presc = ^presc_i;
endmodule

bind sent_rx_clk_comp sent_rx_clk_comp_chk #(.PRESC_W(PRESC_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .presc_i      (presc_i),
  .rx_i         (rx_i),
  .tick_o       (tick_o),
  .comp_presc_o (comp_presc_o),
  .comp_valid_o (comp_valid_o)
);

// File: tb/test_sent_rx_clk_comp.sv
`timescale 1ns/1ps
module test_sent_rx_clk_comp;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] presc_i = 8'd0;
  logic       rx_i = 1'b1;
  logic       tick_o;
  logic [8:0] comp_presc_o;
  logic       comp_valid_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sent_rx_clk_comp i_sent_rx_clk_comp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .presc_i      (presc_i),
    .rx_i         (rx_i),
    .tick_o       (tick_o),
    .comp_presc_o (comp_presc_o),
    .comp_valid_o (comp_valid_o)
  );

  typedef struct packed {
    logic [7:0]  presc;
    logic [15:0] len;
    logic        vld;
    logic [8:0]  comp;
  } vec_t;

  // expected comp = floor((L+28)/56) when 168P <= 4L <= 280P, else previous value
  localparam vec_t VECS [12] = '{
    '{8'd4,   16'd224,   1'b1, 9'd4},
    '{8'd4,   16'd252,   1'b1, 9'd5},
    '{8'd4,   16'd167,   1'b0, 9'd5},
    '{8'd4,   16'd168,   1'b1, 9'd3},
    '{8'd4,   16'd280,   1'b1, 9'd5},
    '{8'd4,   16'd281,   1'b0, 9'd5},
    '{8'd10,  16'd560,   1'b1, 9'd10},
    '{8'd10,  16'd587,   1'b1, 9'd10},
    '{8'd10,  16'd588,   1'b1, 9'd11},
    '{8'd0,   16'd56,    1'b0, 9'd11},
    '{8'd200, 16'd11200, 1'b1, 9'd200},
    '{8'd200, 16'd14000, 1'b1, 9'd250}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fall now, next fall after len cycles
  task automatic fall_pulse(input int len);
    rx_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (len - 3) @(negedge clk_i);
  endtask

  // closing fall, then count strobes over 30 cycles
  task automatic close_count(output int nv);
    nv = 0;
    rx_i = 1'b0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk_i);
      if (i == 3) rx_i = 1'b1;
      if (comp_valid_o) nv++;
    end
  endtask

  task automatic period(output int p);
    int guard;
    guard = 0;
    p = 0;
    @(negedge clk_i);
    while (!tick_o && guard < 2000) begin @(negedge clk_i); guard++; end
    @(negedge clk_i);
    p = 1;
    while (!tick_o && p < 2000) begin @(negedge clk_i); p++; end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, nv, first;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset tick", int'(tick_o), 0);
    chk("R1 reset comp", int'(comp_presc_o), 0);
    chk("R1 reset valid", int'(comp_valid_o), 0);
    presc_i = 8'd3;
    repeat (20) @(negedge clk_i);
    chk("R1 disabled tick", int'(tick_o), 0);

    en_i = 1'b1;
    period(p); chk("R2 period presc 3", p, 3);
    presc_i = 8'd0;
    period(p); period(p); chk("R2 period presc 0", p, 1);
    presc_i = 8'd7;
    period(p); period(p); chk("R2 period presc 7", p, 7);

    // R3 restart and R7 first fall after enable
    presc_i = 8'd4;
    @(negedge clk_i);
    rx_i = 1'b0;
    first = 0; nv = 0;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk_i);
      if (n == 2) rx_i = 1'b1;
      if (tick_o && first == 0) first = n;
      if (comp_valid_o) nv++;
    end
    chk("R3 first tick after fall", first, 5);
    chk("R7 first fall no strobe", nv, 0);

    foreach (VECS[k]) begin
      presc_i = VECS[k].presc;
      fall_pulse(int'(VECS[k].len));
      close_count(nv);
      chk(VECS[k].vld ? "R4 R5 strobe count" : "R4 R6 strobe count", nv, int'(VECS[k].vld));
      chk(VECS[k].vld ? "R5 comp value" : "R6 comp held", int'(comp_presc_o), int'(VECS[k].comp));
    end

    presc_i = 8'd3;
    period(p); period(p); chk("R9 period follows comp", p, 250);

    // R8 pause pulse taken first, real sync after
    presc_i = 8'd4;
    fall_pulse(270);
    fall_pulse(224);
    chk("R8 pause value", int'(comp_presc_o), 5);
    close_count(nv);
    chk("R8 strobe", nv, 1);
    chk("R8 corrected value", int'(comp_presc_o), 4);

    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 disable clears comp", int'(comp_presc_o), 0);
    chk("R1 disable tick", int'(tick_o), 0);
    en_i = 1'b1;
    presc_i = 8'd6;
    period(p); period(p); chk("R10 period back to presc", p, 6);

    presc_i = 8'd4;
    repeat (224) @(negedge clk_i);
    close_count(nv);
    chk("R7 fall after enable", nv, 0);
    fall_pulse(224);
    close_count(nv);
    chk("R5 strobe after enable", nv, 1);
    chk("R5 value after enable", int'(comp_presc_o), 4);

    finish_run();
  end
endmodule